// File: doc/BRIEF.md
# Tamper-Evident Mission Sample Counters

This block keeps the evidence a sampling datalogger needs to show that its log has not been wiped. It holds two saturating sample counters and a mission-active flag. The mission counter restarts at zero each time logging begins. The lifetime counter keeps running across missions and is cleared only by power-on reset. Both counters advance on a sample strobe, but only while a mission is active.

The block watches the register write bus of the logger. A non-zero write to the sample-rate register starts a mission. A zero write to that register ends the mission. A write to any other clock or control register, except the status register, also ends the mission. To check the log, a host reads the lifetime count before a mission and again after it. The host then compares the difference with the mission count. If the log was cleared or restarted in between, the two values no longer agree.

Both counters are read through a byte-wide read port with a combinational result.

Top module: `mission_tally`

## Requirements
- R1: After reset, the flag `mission_active` is 0, both counters are 0, and every read address returns 0.
- R2: A write of a non-zero value to the sample-rate address (default 0x0D) sets `mission_active` at that clock edge and clears the mission counter to 0.
- R3: While `mission_active` is 1, each cycle with `sample_stb` high adds one to both counters.
- R4: While `mission_active` is 0, `sample_stb` has no effect on either counter.
- R5: A write of zero to the sample-rate address clears `mission_active` and leaves both counter values unchanged.
- R6: A write to any address in the protected range (default 0x00 to 0x0F) other than the status address and the sample-rate address clears `mission_active` and leaves both counter values unchanged.
- R7: A write to the status address (default 0x0E), or to any address outside the protected range, leaves `mission_active` unchanged.
- R8: The lifetime counter never decreases. No register write and no mission start resets it.
- R9: Both counters saturate at all-ones. Further strobes hold them at that value.
- R10: The mission counter is read at MISSION_BASE+k (default 0x10) and the lifetime counter at LIFE_BASE+k (default 0x13). Here k = 0..ceil(CNT_W/8)-1, and byte k holds bits 8k+7..8k, so the least significant byte comes first. Any other read address returns 0.
- R11: If neither counter saturates, the mission count at the end of a mission equals the lifetime count at the end minus the lifetime count at the start.
- R12: A strobe in the same cycle as a register write is judged by the flag value before that write. A start write takes priority over a strobe for the mission counter, so the mission counter becomes 0 while the lifetime counter still counts a strobe that occurs during an active mission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| sample_stb | input | 1 | One pulse per sample taken |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| mission_active | output | 1 | Mission-in-progress flag |

## Verification
The bench builds the block with CNT_W = 12 and the default 5-bit address map.

- **Saturation.** With this width, saturation at 4095 takes only a few thousand strobes, so the bench can drive both counters to all-ones and past it.
- **Byte order.** With two bytes per counter, the least-significant-byte-first order is still visible, and the unused third byte slot is exercised as an unmapped address.
- **Address coverage.** The 32-entry address space is small enough for the bench to write every address during an active mission. After each step it also reads back every address.

// File: rtl/mst_pkg.sv
package mst_pkg;

  // Write-bus events the tracker reacts to
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_START = 2'd1,
    EV_STOP  = 2'd2,
    EV_ABORT = 2'd3
  } wr_event_e;

  localparam int unsigned ADDR_MAX_W = 16;

  // Classify one register write. Address arguments are zero-extended to ADDR_MAX_W.
  function automatic wr_event_e classify_write(
    input logic                  en,
    input logic [ADDR_MAX_W-1:0] addr,
    input logic [7:0]            data,
    input logic [ADDR_MAX_W-1:0] rate_addr,
    input logic [ADDR_MAX_W-1:0] status_addr,
    input logic [ADDR_MAX_W-1:0] prot_lo,
    input logic [ADDR_MAX_W-1:0] prot_hi
  );
    wr_event_e ev;
    ev = EV_NONE;
    if (en) begin
      if (addr == rate_addr) begin
        ev = (data != 8'd0) ? EV_START : EV_STOP;
      end else if (addr != status_addr && addr >= prot_lo && addr <= prot_hi) begin
        ev = EV_ABORT;
      end
    end
    return ev;
  endfunction

endpackage

// File: rtl/mst_wr_decode.sv
module mst_wr_decode
  import mst_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned RATE_ADDR   = 13,
  parameter int unsigned STATUS_ADDR = 14,
  parameter int unsigned PROT_LO     = 0,
  parameter int unsigned PROT_HI     = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              start_evt,
  output logic              stop_evt,
  output logic              abort_evt
);

  localparam logic [ADDR_MAX_W-1:0] RATE_A   = ADDR_MAX_W'(RATE_ADDR);
  localparam logic [ADDR_MAX_W-1:0] STATUS_A = ADDR_MAX_W'(STATUS_ADDR);
  localparam logic [ADDR_MAX_W-1:0] LO_A     = ADDR_MAX_W'(PROT_LO);
  localparam logic [ADDR_MAX_W-1:0] HI_A     = ADDR_MAX_W'(PROT_HI);

  wr_event_e ev;

  always_comb begin
    ev = classify_write(wr_en, ADDR_MAX_W'(wr_addr), wr_data, RATE_A, STATUS_A, LO_A, HI_A);
  end

  assign start_evt = (ev == EV_START);
  assign stop_evt  = (ev == EV_STOP);
  assign abort_evt = (ev == EV_ABORT);

  // R7: a status write never raises an event
  p_status_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ADDR_MAX_W'(wr_addr) == STATUS_A) |-> !(start_evt || stop_evt || abort_evt));

  // R7: writes outside the protected range cannot abort
  p_outside_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ADDR_MAX_W'(wr_addr) > HI_A || ADDR_MAX_W'(wr_addr) < LO_A) |-> !abort_evt);

endmodule

// File: rtl/mst_sat_counter.sv
module mst_sat_counter #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         at_max
);

  localparam logic [W-1:0] ALL_ONES = '1;
  localparam logic [W-1:0] ONE      = W'(1);

  function automatic logic [W-1:0] sat_next(input logic [W-1:0] v);
    return (v == ALL_ONES) ? v : v + ONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= sat_next(cnt);
  end

  assign at_max = (cnt == ALL_ONES);

  // R3: a strobe below the ceiling advances by exactly one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && !at_max) |=> (cnt == $past(cnt) + ONE));

  // R9: at the ceiling the value holds
  p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && at_max) |=> at_max);

  // R4: with no strobe and no clear, the value is stable
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt));

endmodule

// File: rtl/mst_readback.sv
module mst_readback #(
  parameter int unsigned ADDR_W       = 5,
  parameter int unsigned CNT_W        = 24,
  parameter int unsigned MISSION_BASE = 16,
  parameter int unsigned LIFE_BASE    = 19
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  mission_cnt,
  input  logic [CNT_W-1:0]  life_cnt,
  output logic [7:0]        rd_data,
  output logic              rd_hit
);

  localparam int unsigned NBYTES = (CNT_W + 7) / 8;
  localparam int unsigned PAD_W  = NBYTES * 8;

  logic [PAD_W-1:0] mis_pad;
  logic [PAD_W-1:0] life_pad;
  logic [7:0]       mis_b  [NBYTES];
  logic [7:0]       life_b [NBYTES];

  assign mis_pad  = PAD_W'(mission_cnt);
  assign life_pad = PAD_W'(life_cnt);

  for (genvar k = 0; k < NBYTES; k++) begin : g_bytes
    assign mis_b[k]  = mis_pad[8*k +: 8];
    assign life_b[k] = life_pad[8*k +: 8];
  end

  always_comb begin
    rd_data = 8'd0;
    rd_hit  = 1'b0;
    for (int k = 0; k < NBYTES; k++) begin
      if (rd_addr == ADDR_W'(MISSION_BASE + k)) begin
        rd_data = mis_b[k];
        rd_hit  = 1'b1;
      end
      if (rd_addr == ADDR_W'(LIFE_BASE + k)) begin
        rd_data = life_b[k];
        rd_hit  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/mission_tally.sv
module mission_tally #(
  parameter int unsigned ADDR_W       = 5,
  parameter int unsigned CNT_W        = 24,
  parameter int unsigned RATE_ADDR    = 13,
  parameter int unsigned STATUS_ADDR  = 14,
  parameter int unsigned PROT_LO      = 0,
  parameter int unsigned PROT_HI      = 15,
  parameter int unsigned MISSION_BASE = 16,
  parameter int unsigned LIFE_BASE    = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              sample_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              mission_active
);

  logic             start_evt, stop_evt, abort_evt;
  logic             count_en;
  logic [CNT_W-1:0] mission_cnt, life_cnt;
  logic             mission_max, life_max;
  logic             rd_hit;

  mst_wr_decode #(
    .ADDR_W(ADDR_W), .RATE_ADDR(RATE_ADDR), .STATUS_ADDR(STATUS_ADDR),
    .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)
  ) u_decode (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start_evt(start_evt), .stop_evt(stop_evt), .abort_evt(abort_evt)
  );

  // Mission flag: a start takes effect at its own edge, stop and abort at theirs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     mission_active <= 1'b0;
    else if (start_evt)             mission_active <= 1'b1;
    else if (stop_evt || abort_evt) mission_active <= 1'b0;
  end

  // A strobe counts only against the flag value held before this edge
  assign count_en = mission_active && sample_stb;

  mst_sat_counter #(.W(CNT_W)) u_mission (
    .clk(clk), .rst_n(rst_n), .clr(start_evt), .inc(count_en),
    .cnt(mission_cnt), .at_max(mission_max)
  );

  mst_sat_counter #(.W(CNT_W)) u_life (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .inc(count_en),
    .cnt(life_cnt), .at_max(life_max)
  );

  mst_readback #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MISSION_BASE(MISSION_BASE), .LIFE_BASE(LIFE_BASE)
  ) u_read (
    .rd_addr(rd_addr), .mission_cnt(mission_cnt), .life_cnt(life_cnt),
    .rd_data(rd_data), .rd_hit(rd_hit)
  );

  // R2: a start write leaves the flag set and the mission count at zero
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (mission_active && mission_cnt == '0));

  // R5: a zero-rate write stops the mission without touching an idle count
  p_stop_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !sample_stb) |=> (!mission_active && $stable(mission_cnt) && $stable(life_cnt)));

  // R6: a protected write aborts the mission
  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !mission_active);

  // R4: strobes while idle change nothing
  p_idle_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mission_active && !start_evt) |=> ($stable(mission_cnt) && $stable(life_cnt)));

  // R8: the lifetime count never goes down
  p_life_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (life_cnt >= $past(life_cnt)));

  // R9: a saturated lifetime count stays saturated
  p_life_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    life_max |=> life_max);

  // R10: unmapped read addresses return zero
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (rd_data == 8'd0));

  // R11: while both counters advance together, their difference is preserved
  p_lockstep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !start_evt && !life_max && !mission_max)
      |=> (life_cnt - mission_cnt == $past(life_cnt) - $past(mission_cnt)));

endmodule

// File: tb/tb_mission_tally.sv
`timescale 1ns/1ps
module tb_mission_tally;

  localparam int ADDR_W = 5;
  localparam int CNT_W  = 12;
  localparam int MAXV   = (1 << CNT_W) - 1;
  localparam int RATE   = 13;
  localparam int STAT   = 14;
  localparam int MBASE  = 16;
  localparam int LBASE  = 19;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic              sample_stb = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [7:0]        rd_data;
  logic              mission_active;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  int exp_mis  = 0;
  int exp_life = 0;
  bit exp_flag = 0;

  always #5 clk = ~clk;

  mission_tally #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sample_stb(sample_stb), .rd_addr(rd_addr), .rd_data(rd_data),
    .mission_active(mission_active)
  );

  function automatic int sat_add(int v, int n);
    return (v + n > MAXV) ? MAXV : v + n;
  endfunction

  // Expected read byte computed from the address map
  function automatic int exp_read(int a);
    if (a == MBASE)     return exp_mis % 256;
    if (a == MBASE + 1) return exp_mis / 256;
    if (a == LBASE)     return exp_life % 256;
    if (a == LBASE + 1) return exp_life / 256;
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock with the given write/strobe, updating the model at the edge
  task automatic step(bit we, int a, int d, bit s);
    bit st, sp, ab, cnt;
    @(negedge clk);
    wr_en = we; wr_addr = ADDR_W'(a); wr_data = 8'(d); sample_stb = s;
    @(posedge clk);
    st  = we && a == RATE && d != 0;
    sp  = we && a == RATE && d == 0;
    ab  = we && a <= 15 && a != RATE && a != STAT;
    cnt = exp_flag && s;
    if (cnt) exp_life = sat_add(exp_life, 1);
    if (st) exp_mis = 0;
    else if (cnt) exp_mis = sat_add(exp_mis, 1);
    if (st) exp_flag = 1;
    else if (sp || ab) exp_flag = 0;
    #1;
    wr_en = 0; sample_stb = 0;
  endtask

  task automatic strobes(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1);
  endtask

  // Sweep every read address plus the flag
  task automatic check_all(string req);
    @(negedge clk);
    check(req, mission_active, exp_flag);
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      rd_addr = ADDR_W'(a);
      #0.2;
      check(req, rd_data, exp_read(a));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int life0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check_all("R1");

    strobes(5);
    check_all("R4");

    step(1, RATE, 8'h20, 0);
    check_all("R2");

    strobes(7);
    check_all("R3");

    // Write every address during a live mission
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      if (a == RATE) continue;
      step(1, RATE, 1, 0);
      strobes(2);
      step(1, a, 8'h55, 0);
      check_all((a <= 15 && a != STAT) ? "R6" : "R7");
      strobes(1);
      check_all((a <= 15 && a != STAT) ? "R4" : "R3");
    end

    step(1, RATE, 1, 0);
    strobes(4);
    step(1, RATE, 0, 0);
    check_all("R5");
    strobes(3);
    check_all("R5");

    life0 = exp_life;
    step(1, RATE, 9, 0);
    strobes(37);
    step(1, 3, 8'hAA, 0);
    check_all("R11");
    check("R11", (exp_read(MBASE) + 256 * exp_read(MBASE + 1)), 37);
    begin
      int life_hw, mis_hw;
      rd_addr = ADDR_W'(LBASE); #0.2; life_hw = rd_data;
      rd_addr = ADDR_W'(LBASE + 1); #0.2; life_hw += 256 * rd_data;
      rd_addr = ADDR_W'(MBASE); #0.2; mis_hw = rd_data;
      rd_addr = ADDR_W'(MBASE + 1); #0.2; mis_hw += 256 * rd_data;
      check("R11", mis_hw, life_hw - life0);
    end

    // Coincident write and strobe
    step(1, RATE, 2, 1);
    check_all("R12");
    strobes(3);
    step(1, RATE, 5, 1);
    check_all("R12");
    strobes(2);
    step(1, 7, 8'h01, 1);
    check_all("R12");

    step(1, RATE, 1, 0);
    check_all("R8");

    // Drive both counters into saturation
    strobes(MAXV + 10);
    check_all("R9");
    strobes(4);
    check_all("R9");
    step(1, RATE, 3, 0);
    strobes(2);
    check_all("R8");

    finish_run();
  end

endmodule